// File: doc/BRIEF.md
# Shared Refresh Request Timer

This block produces periodic refresh service requests for a group of programmable memory machines that share one refresh schedule. Two cascaded counters divide the system clock: a prescaler whose limit is set by `prescale_i`, then a period counter whose limit is set by `period_i`. Each wrap of the second counter is one refresh tick. Every tick uses the refresh pattern held by machine 0, which is the refresh executor. A bank takes part in a refresh when the machine that owns it has its refresh-enable bit set. Machine 0 must itself be enabled for any refresh to happen at all.

A tick raises `rfsh_req_o`. At the same moment the bank select vector `rfsh_bank_sel_o` is captured. The request then stays up until the pattern sequencer returns `rfsh_ack_i`. A tick that arrives while a request is still outstanding is not queued. It sets `rfsh_overrun_o` instead. This timer is an alternative to a dedicated SDRAM refresh engine and must not run at the same time. While `sdram_rfsh_active_i` is high, the timer is held idle with both counters cleared.

The controller has three states:
- OFF: the timer is disabled and the counters are cleared.
- COUNT: the counters are running and no request is outstanding.
- PEND: a request is outstanding.

The transitions are:
- OFF to COUNT when the timer becomes enabled.
- OFF or COUNT to PEND on a tick.
- COUNT to OFF when the timer becomes disabled.
- PEND to COUNT on an acknowledge while the timer is enabled.
- PEND to OFF on an acknowledge while the timer is disabled.

Top module: `shared_refresh_timer`

## Requirements
- R1: With prescale value P and a non-zero period value N, the first request is visible N*(P+1) clock cycles after the timer becomes enabled. Later requests follow every N*(P+1) cycles.
- R2: A period value of 0 disables the timer and holds both counters at zero, so no request is raised. After a non-zero N is written, counting starts again from zero.
- R3: While bit 0 of `mach_rfen_i` (machine 0 enable) is clear, no request is raised.
- R4: While `sdram_rfsh_active_i` is high, no request is raised and both counters are held at zero.
- R5: Once raised, `rfsh_req_o` stays high until a cycle in which `rfsh_ack_i` is high. It is low in the cycle after that acknowledge.
- R6: Bank b is owned by the machine whose code sits in `bank_owner_i[2b+1:2b]`. A code of 3 means the bank is unassigned.
  - Bit b of `rfsh_bank_sel_o` is 1 exactly when the bank's owner code is below 3 and that machine's `mach_rfen_i` bit is set.
  - The vector is captured in the cycle the request is raised and is held while the request is pending.
- R7: A tick that arrives while a request is pending sets `rfsh_overrun_o` and is not queued. After the acknowledge, the next request comes only at the next tick.
- R8: An acknowledge clears `rfsh_overrun_o`, unless a tick lands in the same cycle.
- R9: After reset, `rfsh_req_o`, `rfsh_bank_sel_o` and `rfsh_overrun_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale_i | input | PRESC_W | Prescaler limit P (divide by P+1) |
| period_i | input | PERIOD_W | Refresh period N in prescaled ticks; 0 disables |
| mach_rfen_i | input | NUM_MACH | Per-machine refresh enable; bit 0 is the executor |
| bank_owner_i | input | NUM_BANK*OWN_W | Owner machine code per bank, 2 bits each, 3 = none |
| sdram_rfsh_active_i | input | 1 | Dedicated SDRAM refresh is in use; holds this timer idle |
| rfsh_ack_i | input | 1 | Sequencer acknowledge that ends the pending request |
| rfsh_req_o | output | 1 | Refresh request, high while pending |
| rfsh_bank_sel_o | output | NUM_BANK | Banks to refresh, captured when the request is raised |
| rfsh_overrun_o | output | 1 | A tick was lost while a request was pending |

## Verification
A counter that starts at the wrong value, or fails to clear while the timer is disabled, shifts the first request away from N*(P+1) cycles. That error is visible at the first request, within tens of cycles. A controller stuck in PEND shows as a request that survives its acknowledge one cycle later. A controller that queues a lost tick shows as an extra request in the cycle after the acknowledge. A select vector that is not frozen at the moment the request is raised shows when enables change mid-request. The same kind of fault shows as an overrun flag that outlives its acknowledge.

// File: rtl/srt_pkg.sv
package srt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_PEND  = 2'd2
    } srt_state_e;
endpackage

// File: rtl/srt_div_stage.sv
// One divider stage: counts steps from zero up to a limit, then wraps.
module srt_div_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         step_i,
    input  logic [W-1:0] last_i,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;
    logic         at_last;

    // Treat a count at or above the limit as the end, so a limit lowered mid-count wraps at once.
    assign at_last = (cnt_q >= last_i);
    assign wrap_o  = run_i && step_i && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/srt_bank_map.sv
// Per-bank select: a bank is chosen when its owner machine has refresh enabled.
module srt_bank_map #(
    parameter int NUM_BANK = 8,
    parameter int NUM_MACH = 3,
    parameter int OWN_W    = 2
) (
    input  logic [NUM_BANK*OWN_W-1:0] owner_i,
    input  logic [NUM_MACH-1:0]       rfen_i,
    output logic [NUM_BANK-1:0]       sel_o
);
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic [OWN_W-1:0] own;
        assign own = owner_i[b*OWN_W +: OWN_W];
        always_comb begin
            sel_o[b] = 1'b0;
            for (int m = 0; m < NUM_MACH; m++) begin
                if (own == OWN_W'(m) && rfen_i[m]) sel_o[b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/srt_ctrl.sv
// Request controller: OFF / COUNT / PEND.
module srt_ctrl
    import srt_pkg::*;
#(
    parameter int NUM_BANK = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                tick_i,
    input  logic                ack_i,
    input  logic [NUM_BANK-1:0] sel_i,
    output logic                req_o,
    output logic [NUM_BANK-1:0] sel_o,
    output logic                ovr_o
);
    srt_state_e state_q, state_d;
    logic       pend;
    logic       raise;

    assign pend  = (state_q == ST_PEND);
    assign raise = !pend && (state_d == ST_PEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (tick_i)     state_d = ST_PEND;
                else if (run_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (tick_i)      state_d = ST_PEND;
                else if (!run_i) state_d = ST_OFF;
            end
            ST_PEND: begin
                if (ack_i) state_d = run_i ? ST_COUNT : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Output registers: select captured on raise, overrun sticky until acknowledged.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o <= '0;
            ovr_o <= 1'b0;
        end else begin
            if (raise) sel_o <= sel_i;
            ovr_o <= (ovr_o && !(pend && ack_i)) || (pend && tick_i);
        end
    end

    assign req_o = pend;
endmodule

// File: rtl/shared_refresh_timer.sv
module shared_refresh_timer #(
    parameter int PRESC_W  = 8,
    parameter int PERIOD_W = 8,
    parameter int NUM_MACH = 3,
    parameter int NUM_BANK = 8,
    parameter int OWN_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PRESC_W-1:0]        prescale_i,
    input  logic [PERIOD_W-1:0]       period_i,
    input  logic [NUM_MACH-1:0]       mach_rfen_i,
    input  logic [NUM_BANK*OWN_W-1:0] bank_owner_i,
    input  logic                      sdram_rfsh_active_i,
    input  logic                      rfsh_ack_i,
    output logic                      rfsh_req_o,
    output logic [NUM_BANK-1:0]       rfsh_bank_sel_o,
    output logic                      rfsh_overrun_o
);
    localparam logic [PERIOD_W-1:0] PERIOD_ONE = PERIOD_W'(1);

    logic                run;
    logic                pre_wrap;
    logic                tick;
    logic [NUM_BANK-1:0] sel_now;

    // Disabled without the executor, with period zero, or when SDRAM refresh owns the job.
    assign run = (period_i != '0) && mach_rfen_i[0] && !sdram_rfsh_active_i;

    srt_div_stage #(.W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .step_i (1'b1),
        .last_i (prescale_i),
        .wrap_o (pre_wrap)
    );

    srt_div_stage #(.W(PERIOD_W)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .step_i (pre_wrap),
        .last_i (period_i - PERIOD_ONE),
        .wrap_o (tick)
    );

    srt_bank_map #(
        .NUM_BANK (NUM_BANK),
        .NUM_MACH (NUM_MACH),
        .OWN_W    (OWN_W)
    ) u_map (
        .owner_i (bank_owner_i),
        .rfen_i  (mach_rfen_i),
        .sel_o   (sel_now)
    );

    srt_ctrl #(.NUM_BANK(NUM_BANK)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick),
        .ack_i  (rfsh_ack_i),
        .sel_i  (sel_now),
        .req_o  (rfsh_req_o),
        .sel_o  (rfsh_bank_sel_o),
        .ovr_o  (rfsh_overrun_o)
    );
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
    parameter int PERIOD_W = 8,
    parameter int NUM_BANK = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PERIOD_W-1:0] period_i,
    input logic                exec_en_i,
    input logic                sdram_i,
    input logic                ack_i,
    input logic                req_i,
    input logic [NUM_BANK-1:0] sel_i,
    input logic                ovr_i
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !ack_i |=> req_i);
    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && ack_i |=> !req_i);
    // R6
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !ack_i |=> $stable(sel_i));
    // R2
    period_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) && !req_i |=> !req_i);
    // R3
    exec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en_i && !req_i |=> !req_i);
    // R4
    sdram_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_i && !req_i |=> !req_i);
    // R7
    overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_i) |-> $past(req_i));
endmodule

bind shared_refresh_timer srt_checker #(
    .PERIOD_W (PERIOD_W),
    .NUM_BANK (NUM_BANK)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_i  (period_i),
    .exec_en_i (mach_rfen_i[0]),
    .sdram_i   (sdram_rfsh_active_i),
    .ack_i     (rfsh_ack_i),
    .req_i     (rfsh_req_o),
    .sel_i     (rfsh_bank_sel_o),
    .ovr_i     (rfsh_overrun_o)
);

// File: tb/shared_refresh_timer_tb_top.sv
`timescale 1ns/1ps
module shared_refresh_timer_tb_top;
    typedef struct packed {
        logic [7:0]  pre;
        logic [7:0]  per;
        logic [2:0]  rfen;
        logic [15:0] own;
        logic [7:0]  sel;
    } vec_t;

    // Owner map 16'hE4E4: banks 0..7 owned by 0,1,2,none,0,1,2,none.
    localparam vec_t VECS [5] = '{
        '{pre: 8'd0, per: 8'd4, rfen: 3'b001, own: 16'hE4E4, sel: 8'h11},
        '{pre: 8'd2, per: 8'd3, rfen: 3'b111, own: 16'hE4E4, sel: 8'h77},
        '{pre: 8'd1, per: 8'd5, rfen: 3'b101, own: 16'hE4E4, sel: 8'h55},
        '{pre: 8'd3, per: 8'd1, rfen: 3'b011, own: 16'hE4E4, sel: 8'h33},
        '{pre: 8'd0, per: 8'd3, rfen: 3'b111, own: 16'hFFFF, sel: 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  prescale;
    logic [7:0]  period;
    logic [2:0]  rfen;
    logic [15:0] owner;
    logic        sdram;
    logic        ack;
    logic        req;
    logic [7:0]  sel;
    logic        ovr;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    shared_refresh_timer dut_i (
        .clk                 (clk),
        .rst_n               (rst_n),
        .prescale_i          (prescale),
        .period_i            (period),
        .mach_rfen_i         (rfen),
        .bank_owner_i        (owner),
        .sdram_rfsh_active_i (sdram),
        .rfsh_ack_i          (ack),
        .rfsh_req_o          (req),
        .rfsh_bank_sel_o     (sel),
        .rfsh_overrun_o      (ovr)
    );

    task automatic check(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Count cycles with the request high over a window (used for "no request" checks).
    task automatic quiet_window(input int cycles, input string what);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (req) hits++;
        end
        check(hits == 0, what, hits, 0);
    endtask

    task automatic run_vec(input vec_t t);
        int n;
        int tp;
        tp = (int'(t.pre) + 1) * int'(t.per);
        @(negedge clk);
        sdram = 1'b1; prescale = t.pre; period = t.per; rfen = t.rfen; owner = t.own;
        @(negedge clk);
        sdram = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!req && n < 1000);
        check(n == tp, "R1 first request delay", n, tp);
        check(sel == t.sel, "R6 bank select", int'(sel), int'(t.sel));
        ack = 1'b1;
        @(negedge clk); n++;
        ack = 1'b0;
        check(req == 1'b0, "R5 request drops after ack", int'(req), 0);
        while (!req && n < 2000) begin @(negedge clk); n++; end
        check(n == 2 * tp, "R1 repeat period", n, 2 * tp);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0; sdram = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; sdram = 1'b1; ack = 1'b0;
        prescale = '0; period = '0; rfen = '0; owner = '0;
        repeat (3) @(negedge clk);
        check(req == 1'b0, "R9 reset request", int'(req), 0);
        check(sel == 8'h00, "R9 reset select", int'(sel), 0);
        check(ovr == 1'b0, "R9 reset overrun", int'(ovr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 5; v++) run_vec(VECS[v]);

        // R4: dedicated SDRAM refresh active keeps the timer quiet
        prescale = 8'd0; period = 8'd2; rfen = 3'b001; owner = 16'hE4E4; sdram = 1'b1;
        quiet_window(30, "R4 no request with SDRAM refresh");

        // R2: period zero holds everything, then restart from zero
        period = 8'd0; sdram = 1'b0;
        quiet_window(30, "R2 no request with period zero");
        period = 8'd2;
        n = 0;
        do begin @(negedge clk); n++; end while (!req && n < 100);
        check(n == 2, "R2 restart delay", n, 2);
        ack = 1'b1; @(negedge clk);
        ack = 1'b0; sdram = 1'b1; @(negedge clk);

        // R3: executor disabled while others enabled
        rfen = 3'b110; sdram = 1'b0;
        quiet_window(30, "R3 no request without machine 0");
        sdram = 1'b1; @(negedge clk);

        // R7 / R8 / R6: overrun while pending, frozen select, no queued request
        prescale = 8'd0; period = 8'd3; rfen = 3'b001; owner = 16'hE4E4;
        @(negedge clk);
        sdram = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!req && n < 100);
        check(n == 3, "R1 overrun test first request", n, 3);
        check(ovr == 1'b0, "R7 no overrun yet", int'(ovr), 0);
        @(negedge clk); // cycle 4
        rfen = 3'b111;
        @(negedge clk); // cycle 5
        @(negedge clk); // cycle 6
        check(ovr == 1'b1, "R7 overrun set by lost tick", int'(ovr), 1);
        check(req == 1'b1, "R5 request held without ack", int'(req), 1);
        check(sel == 8'h11, "R6 select frozen while pending", int'(sel), 8'h11);
        @(negedge clk); // cycle 7
        ack = 1'b1;
        @(negedge clk); // cycle 8
        ack = 1'b0;
        check(req == 1'b0, "R7 lost tick not queued", int'(req), 0);
        check(ovr == 1'b0, "R8 overrun cleared by ack", int'(ovr), 0);
        @(negedge clk); // cycle 9
        check(req == 1'b1, "R7 next request at next tick", int'(req), 1);
        check(sel == 8'h77, "R6 select resampled on new raise", int'(sel), 8'h77);
        ack = 1'b1; @(negedge clk);
        ack = 1'b0; sdram = 1'b1; @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule